// File: doc/BRIEF.md
# Prioritized Interrupt Vector Generator

This block gathers interrupt requests from eight serial channels and from four parallel-port sources, and drives a single interrupt line to a processor. Each channel owns four request groups. Groups 0, 1 and 2 are urgent single-event receive or transmit indications. They arrive as one-cycle pulses and are held in sticky flags. Group 3 is a level that summarises every other source of the channel. That level is cleared by software in logic outside this block.

When the processor runs an acknowledge cycle (`ack_start` pulse, later `ack_done` pulse), the block picks the winning request, latches an 8-bit vector and presents it with a valid flag until the cycle ends. The ordering is: lowest group number first, then lowest channel number within that group.

A mode input chooses between two vector formats. The narrow format packs address, port-pending flag, channel and group. The wide format packs a 6-bit device address and the group only. In the wide format, software reads the channel number from the global status output. When the cycle finishes, the reported urgent flag clears itself. A group-3 report does not clear anything.

Top module: `irq_vector_gen`

## Requirements
- R1: After synchronous reset, `irq_out`, `vec_valid`, `vec_out` and `gstat_out` are all zero.
- R2: When several groups are pending, the vector reports the lowest-numbered group, whatever the channel numbers are.
- R3: Within the winning group, the vector reports the lowest-numbered requesting channel.
- R4: With `mode_wide`=0 at `ack_start`, `vec_out` = {`dev_addr`[1:0], PI, channel[2:0], group[1:0]}, from bit 7 down to bit 0.
- R5: With `mode_wide`=1 at `ack_start`, `vec_out` = {`dev_addr`[5:0], group[1:0]}, and `gstat_out`[2:0] holds the reported channel number.
- R6: An urgent flag set through `urg_req`[g*8+c] (group g in 0..2, channel c) is cleared by the `ack_done` that ends the cycle which reported it. Other pending flags are untouched.
- R7: A group-3 report (`misc_lvl`[c]) is never cleared by an acknowledge. It is reported again for as long as the level stays high.
- R8: `irq_out` rises two cycles after a request input is sampled. It stays high while any urgent flag, group-3 level or port input is active, and falls only once all of them are clear.
- R9: `vec_valid` rises the cycle after `ack_start` and falls the cycle after `ack_done`. In between, `vec_out` and `gstat_out`[2:0] hold steady even if new requests arrive.
- R10: `gstat_out`[7:4] shows the port inputs one cycle delayed, independently of the channel requests. PI is the OR of those flags when the acknowledge starts. If no channel request is pending, the vector reports group 3, channel 7.
- R11: A new pulse for the same flag in the cycle of the `ack_done` that clears it leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wide | input | 1 | Vector format select, sampled at ack_start |
| dev_addr | input | 6 | Device address placed into the vector |
| urg_req | input | 24 | Urgent request pulses, bit g*8+c = group g, channel c |
| misc_lvl | input | 8 | Group-3 request level per channel |
| port_req | input | 4 | Parallel-port request levels |
| ack_start | input | 1 | Acknowledge cycle start strobe |
| ack_done | input | 1 | Acknowledge cycle end strobe |
| irq_out | output | 1 | Interrupt request to the processor |
| vec_out | output | 8 | Latched interrupt vector |
| vec_valid | output | 1 | Vector is being presented |
| gstat_out | output | 8 | Global status: port flags [7:4], zero [3], channel [2:0] |

## Verification
The hardest case is a collision at the end of an acknowledge: a fresh pulse for the very flag being cleared lands in the same cycle as `ack_done`. The stimulus gets there by running the start half of the cycle, then driving the end strobe and the repeat pulse on one edge. It then proves the flag survived by acknowledging again. A second awkward case is a higher-priority request that arrives while a vector is on the bus. It must not disturb the latched vector, yet it must win the next cycle. The bench injects it between the two strobes and holds the cycle open for several clocks.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int CH_BITS  = 3;
  localparam int GRP_BITS = 2;
  localparam int NUM_GRP  = 4;
  localparam int NUM_URG  = 3;
  localparam int VEC_BITS = 8;

  typedef struct packed {
    logic                hit;
    logic [CH_BITS-1:0]  chan;
    logic [GRP_BITS-1:0] grp;
  } irq_sel_t;
endpackage

// File: rtl/urg_flags.sv
module urg_flags
  import irq_vec_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_URG*NUM_CH-1:0] set_pulse,
  input  logic                    clr_en,
  input  logic [GRP_BITS-1:0]     clr_grp,
  input  logic [CH_BITS-1:0]      clr_chan,
  output logic [NUM_URG*NUM_CH-1:0] pend
);
  for (genvar g = 0; g < NUM_URG; g++) begin : g_grp
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit_clr;
      assign hit_clr = clr_en && (clr_grp == GRP_BITS'(g)) && (clr_chan == CH_BITS'(c));
      always_ff @(posedge clk) begin
        if (rst)
          pend[g*NUM_CH+c] <= 1'b0;
        else if (set_pulse[g*NUM_CH+c])
          pend[g*NUM_CH+c] <= 1'b1;
        else if (hit_clr)
          pend[g*NUM_CH+c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/prio_pick.sv
module prio_pick
  import irq_vec_pkg::*;
#(
  parameter int NUM_CH = 8
) (
  input  logic [NUM_GRP*NUM_CH-1:0] active,
  output irq_sel_t                  sel
);
  always_comb begin
    sel.hit  = 1'b0;
    sel.chan = CH_BITS'(NUM_CH-1);
    sel.grp  = GRP_BITS'(NUM_GRP-1);
    for (int g = NUM_GRP-1; g >= 0; g--) begin
      for (int c = NUM_CH-1; c >= 0; c--) begin
        if (active[g*NUM_CH+c]) begin
          sel.hit  = 1'b1;
          sel.chan = CH_BITS'(c);
          sel.grp  = GRP_BITS'(g);
        end
      end
    end
  end
endmodule

// File: rtl/vec_fmt.sv
module vec_fmt
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic                mode_wide,
  input  logic [ADDR_W-1:0]   dev_addr,
  input  logic                port_any,
  input  irq_sel_t            sel,
  output logic [VEC_BITS-1:0] vec
);
  localparam int NARROW_ADDR = VEC_BITS - 1 - CH_BITS - GRP_BITS;
  localparam int WIDE_ADDR   = VEC_BITS - GRP_BITS;

  always_comb begin
    if (mode_wide)
      vec = {dev_addr[WIDE_ADDR-1:0], sel.grp};
    else
      vec = {dev_addr[NARROW_ADDR-1:0], port_any, sel.chan, sel.grp};
  end
endmodule

// File: rtl/irq_vector_gen.sv
module irq_vector_gen
  import irq_vec_pkg::*;
#(
  parameter int NUM_CH   = 8,
  parameter int NUM_PORT = 4,
  parameter int ADDR_W   = 6
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      mode_wide,
  input  logic [ADDR_W-1:0]         dev_addr,
  input  logic [NUM_URG*NUM_CH-1:0] urg_req,
  input  logic [NUM_CH-1:0]         misc_lvl,
  input  logic [NUM_PORT-1:0]       port_req,
  input  logic                      ack_start,
  input  logic                      ack_done,
  output logic                      irq_out,
  output logic [VEC_BITS-1:0]       vec_out,
  output logic                      vec_valid,
  output logic [VEC_BITS-1:0]       gstat_out
);
  localparam int GAP_W = VEC_BITS - NUM_PORT - CH_BITS;

  logic [NUM_URG*NUM_CH-1:0] urg_pend;
  logic [NUM_CH-1:0]         lvl_q;
  logic [NUM_PORT-1:0]       port_q;
  logic [NUM_GRP*NUM_CH-1:0] active;
  irq_sel_t                  cur_sel;
  irq_sel_t                  lat_sel;
  logic [VEC_BITS-1:0]       vec_next;
  logic                      clr_urgent;

  assign active     = {lvl_q, urg_pend};
  assign clr_urgent = ack_done && vec_valid && lat_sel.hit &&
                      (lat_sel.grp != GRP_BITS'(NUM_GRP-1));

  urg_flags #(.NUM_CH(NUM_CH)) u_flags (
    .clk       (clk),
    .rst       (rst),
    .set_pulse (urg_req),
    .clr_en    (clr_urgent),
    .clr_grp   (lat_sel.grp),
    .clr_chan  (lat_sel.chan),
    .pend      (urg_pend)
  );

  prio_pick #(.NUM_CH(NUM_CH)) u_pick (
    .active (active),
    .sel    (cur_sel)
  );

  vec_fmt #(.ADDR_W(ADDR_W)) u_fmt (
    .mode_wide (mode_wide),
    .dev_addr  (dev_addr),
    .port_any  (|port_q),
    .sel       (cur_sel),
    .vec       (vec_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= '0;
      port_q  <= '0;
      irq_out <= 1'b0;
    end else begin
      lvl_q   <= misc_lvl;
      port_q  <= port_req;
      irq_out <= (|urg_pend) || (|lvl_q) || (|port_q);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_out   <= '0;
      vec_valid <= 1'b0;
      lat_sel   <= '0;
    end else if (ack_start) begin
      vec_out   <= vec_next;
      vec_valid <= 1'b1;
      lat_sel   <= cur_sel;
    end else if (ack_done) begin
      vec_valid <= 1'b0;
    end
  end

  assign gstat_out = {port_q, {GAP_W{1'b0}}, lat_sel.chan};
endmodule

// File: rtl/irq_vector_gen_chk.sv
module irq_vector_gen_chk #(
  parameter int NUM_CH   = 8,
  parameter int NUM_PORT = 4,
  parameter int ADDR_W   = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_wide,
  input logic [ADDR_W-1:0] dev_addr,
  input logic [NUM_CH-1:0] misc_lvl,
  input logic [NUM_PORT-1:0] port_req,
  input logic              ack_start,
  input logic              ack_done,
  input logic              irq_out,
  input logic [7:0]        vec_out,
  input logic              vec_valid,
  input logic [7:0]        gstat_out
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (!irq_out && !vec_valid));

  p_narrow_addr_r4: assert property (@(posedge clk) disable iff (rst)
    (ack_start && !mode_wide) |=> (vec_out[7:6] == $past(dev_addr[1:0])));

  p_wide_addr_r5: assert property (@(posedge clk) disable iff (rst)
    (ack_start && mode_wide) |=> (vec_out[7:2] == $past(dev_addr)));

  p_level_raises_irq_r8: assert property (@(posedge clk) disable iff (rst)
    (misc_lvl != '0) |=> ##1 irq_out);

  p_valid_rise_r9: assert property (@(posedge clk) disable iff (rst)
    ack_start |=> vec_valid);

  p_valid_fall_r9: assert property (@(posedge clk) disable iff (rst)
    (ack_done && !ack_start) |=> !vec_valid);

  p_vec_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (vec_valid && !ack_start && !ack_done) |=>
      (vec_valid && $stable(vec_out) && $stable(gstat_out[2:0])));

  p_port_status_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (gstat_out[7:4] == $past(port_req)));
endmodule

bind irq_vector_gen irq_vector_gen_chk #(
  .NUM_CH(NUM_CH), .NUM_PORT(NUM_PORT), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .mode_wide(mode_wide), .dev_addr(dev_addr),
  .misc_lvl(misc_lvl), .port_req(port_req), .ack_start(ack_start),
  .ack_done(ack_done), .irq_out(irq_out), .vec_out(vec_out),
  .vec_valid(vec_valid), .gstat_out(gstat_out)
);

// File: tb/test_irq_vector_gen.sv
module test_irq_vector_gen;
  logic       clk = 1'b0;
  logic       rst;
  logic       mode_wide;
  logic [5:0] dev_addr;
  logic [23:0] urg_req;
  logic [7:0] misc_lvl;
  logic [3:0] port_req;
  logic       ack_start;
  logic       ack_done;
  logic       irq_out;
  logic [7:0] vec_out;
  logic       vec_valid;
  logic [7:0] gstat_out;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] got_vec;
  logic [7:0] got_stat;

  localparam logic [5:0] ADDR = 6'b101101;

  always #4 clk = ~clk;

  irq_vector_gen i_irq_vector_gen (
    .clk(clk), .rst(rst), .mode_wide(mode_wide), .dev_addr(dev_addr),
    .urg_req(urg_req), .misc_lvl(misc_lvl), .port_req(port_req),
    .ack_start(ack_start), .ack_done(ack_done), .irq_out(irq_out),
    .vec_out(vec_out), .vec_valid(vec_valid), .gstat_out(gstat_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] narrow(input logic pi, input int ch, input int g);
    return {ADDR[1:0], pi, ch[2:0], g[1:0]};
  endfunction

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input int ch, input int g);
    urg_req[g*8+ch] = 1'b1;
    @(negedge clk);
    urg_req = '0;
  endtask

  // full acknowledge; optional repeat pulse on the end edge
  task automatic ack(input int rep_ch, input int rep_g);
    ack_start = 1'b1;
    @(negedge clk);
    ack_start = 1'b0;
    got_vec  = vec_out;
    got_stat = gstat_out;
    chk("R9 valid during cycle", 32'(vec_valid), 1);
    ack_done = 1'b1;
    if (rep_ch >= 0) urg_req[rep_g*8+rep_ch] = 1'b1;
    @(negedge clk);
    ack_done = 1'b0;
    urg_req  = '0;
    chk("R9 valid after end", 32'(vec_valid), 0);
  endtask

  task automatic t_reset;
    chk("R1 irq", 32'(irq_out), 0);
    chk("R1 valid", 32'(vec_valid), 0);
    chk("R1 vec", 32'(vec_out), 0);
    chk("R1 gstat", 32'(gstat_out), 0);
  endtask

  task automatic t_group_prio;
    urg_req[1*8+5] = 1'b1;
    urg_req[2*8+2] = 1'b1;
    @(negedge clk);
    urg_req = '0;
    cycles(1);
    chk("R8 irq raised", 32'(irq_out), 1);
    ack(-1, 0);
    chk("R2 group wins", 32'(got_vec), 32'(narrow(0, 5, 1)));
    ack(-1, 0);
    chk("R6 next flag left", 32'(got_vec), 32'(narrow(0, 2, 2)));
    cycles(2);
    chk("R8 irq low when clear", 32'(irq_out), 0);
  endtask

  task automatic t_chan_prio;
    urg_req[0*8+6] = 1'b1;
    urg_req[0*8+3] = 1'b1;
    @(negedge clk);
    urg_req = '0;
    cycles(1);
    ack(-1, 0);
    chk("R3 low channel wins", 32'(got_vec), 32'(narrow(0, 3, 0)));
    ack(-1, 0);
    chk("R3 then channel 6", 32'(got_vec), 32'(narrow(0, 6, 0)));
    cycles(2);
    chk("R6 all cleared", 32'(irq_out), 0);
  endtask

  task automatic t_wide;
    pulse(4, 2);
    cycles(1);
    mode_wide = 1'b1;
    ack(-1, 0);
    mode_wide = 1'b0;
    chk("R5 wide vector", 32'(got_vec), 32'({ADDR, 2'd2}));
    chk("R5 status channel", 32'(got_stat[2:0]), 4);
    cycles(2);
    chk("R6 wide clears", 32'(irq_out), 0);
  endtask

  task automatic t_level;
    misc_lvl = 8'h80;
    pulse(1, 2);
    cycles(1);
    ack(-1, 0);
    chk("R2 urgent before level", 32'(got_vec), 32'(narrow(0, 1, 2)));
    ack(-1, 0);
    chk("R7 level reported", 32'(got_vec), 32'(narrow(0, 7, 3)));
    cycles(2);
    chk("R7 irq held by level", 32'(irq_out), 1);
    ack(-1, 0);
    chk("R7 level again", 32'(got_vec), 32'(narrow(0, 7, 3)));
    misc_lvl = '0;
    cycles(3);
    chk("R8 irq falls after level", 32'(irq_out), 0);
  endtask

  task automatic t_port;
    port_req = 4'b0100;
    cycles(2);
    chk("R10 port status", 32'(gstat_out[7:4]), 32'h4);
    chk("R8 irq from port", 32'(irq_out), 1);
    ack(-1, 0);
    chk("R10 port only vector", 32'(got_vec), 32'(narrow(1, 7, 3)));
    pulse(0, 1);
    cycles(1);
    ack(-1, 0);
    chk("R10 PI with channel", 32'(got_vec), 32'(narrow(1, 0, 1)));
    chk("R10 status independent", 32'(got_stat[7:4]), 32'h4);
    port_req = '0;
    cycles(3);
    chk("R8 irq low", 32'(irq_out), 0);
  endtask

  task automatic t_hold;
    pulse(5, 2);
    cycles(1);
    ack_start = 1'b1;
    @(negedge clk);
    ack_start = 1'b0;
    urg_req[0*8+0] = 1'b1;
    @(negedge clk);
    urg_req = '0;
    cycles(3);
    chk("R9 vector held", 32'(vec_out), 32'(narrow(0, 5, 2)));
    chk("R9 channel held", 32'(gstat_out[2:0]), 5);
    chk("R9 still valid", 32'(vec_valid), 1);
    ack_done = 1'b1;
    @(negedge clk);
    ack_done = 1'b0;
    ack(-1, 0);
    chk("R9 late request next", 32'(got_vec), 32'(narrow(0, 0, 0)));
    cycles(2);
    chk("R6 both cleared", 32'(irq_out), 0);
  endtask

  task automatic t_collide;
    pulse(2, 1);
    cycles(1);
    ack(2, 1);
    chk("R11 first report", 32'(got_vec), 32'(narrow(0, 2, 1)));
    cycles(2);
    chk("R11 flag survives", 32'(irq_out), 1);
    ack(-1, 0);
    chk("R11 reported again", 32'(got_vec), 32'(narrow(0, 2, 1)));
    cycles(2);
    chk("R11 finally clear", 32'(irq_out), 0);
  endtask

  initial begin
    rst = 1'b1; mode_wide = 1'b0; dev_addr = ADDR; urg_req = '0;
    misc_lvl = '0; port_req = '0; ack_start = 1'b0; ack_done = 1'b0;
    cycles(3);
    rst = 1'b0;
    cycles(1);
    t_reset();
    t_group_prio();
    t_chan_prio();
    t_wide();
    t_level();
    t_port();
    t_hold();
    t_collide();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule